// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block turns graphics aperture addresses into physical memory addresses. The first translation level is a directory of 64 slots held on chip. Software loads it one slot at a time through a single packed write port. Each present slot names a 4 KiB page in system memory. That page holds 1024 second-level entries of 32 bits each. For a request, the block works out which directory slot and which entry to use. It then reads that entry through a simple memory read request/response port and returns either the translated address or a fault.

A four-way, fully associative cache keeps recent page translations, so a repeated page is answered without a memory read. Changing the directory does not update the cache. Software invalidates the cache by writing the control register twice: first with the flush bit clear, then with it set. The aperture base and a size code are static inputs. The size code sets how many directory slots are in use. Only one translation is in flight at a time.

Top module: `aperture_xlate`

## Requirements
- R1: After reset, rsp_valid and mem_req_valid are low and req_ready is high. Every directory slot is empty and the cache holds nothing, so any request faults without a memory read.
- R2: A directory write loads the slot named by bits 5:0 of dir_wr_data. The slot takes the page frame from bits 31:12 and the present flag from bit 8. Bits 11:9 and 7:6 have no effect on translation.
- R3: A directory write with bit 8 clear empties its slot. A request that maps to an empty slot faults and issues no memory read.
- R4: The directory slot is addr[31:22] minus ap_base[31:22]. The entry fetch address is {slot frame, addr[21:12], 2'b00}.
- R5: ap_size_code selects the number of slots in use: 0 gives 64, 32 gives 32, 48 gives 16, 56 gives 8, and any other code gives none. An address below the base, or at or above the slots in use, faults with no memory read.
- R6: When the fetched entry has bit 0 set, the response carries {entry[31:12], addr[11:0]} with rsp_fault low. When bit 0 is clear, the response is a fault.
- R7: A request whose page is cached is answered one cycle after it is accepted, with no memory read. The cache holds four pages and replaces the oldest fill first.
- R8: A cache miss on a present slot issues exactly one memory read. The read holds its address until mem_req_ready accepts it. The response follows one cycle after mem_rsp_valid.
- R9: A control write with bit 7 set invalidates the cache only when the previous control write had bit 7 clear. The reset state counts as bit 7 set. Directory writes leave cached translations in place.
- R10: req_ready is low from the acceptance of a missing request until its response. Entries fetched with bit 0 clear are not cached.
- R11: Every fault response carries rsp_addr equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ap_base | input | 32 | Aperture base address; bits 31:22 are used |
| ap_size_code | input | 8 | Aperture size code |
| dir_wr_en | input | 1 | Directory write strobe |
| dir_wr_data | input | 32 | Packed directory write: frame, attribute, present, slot |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control write data; bit 7 drives the flush sequence |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted when high with req_valid |
| req_addr | input | 32 | Aperture address to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Entry read address |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 32 | Second-level entry |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 32 | Translated address, zero on fault |
| rsp_fault | output | 1 | Translation fault |

## Verification
Cache hits and faults caught before any fetch (out of range, empty slot) are due exactly one cycle after the accepting edge. The bench counts falling edges from acceptance and expects the response at the first one. A miss has no fixed latency, because the bench memory stalls mem_req_ready on some cycles and answers two cycles after each accepted read. For a miss, the bench checks that req_ready is low one cycle after acceptance. It then waits for the response pulse and compares it against the scoreboard entry pushed when the request was driven. The number of reads and the last read address are compared only after the response, when the bench memory has recorded every read.

// File: rtl/apx_pkg.sv
package apx_pkg;

   localparam int unsigned ADDR_W      = 32;
   localparam int unsigned PAGE_OFF_W  = 12;
   localparam int unsigned FRAME_W     = ADDR_W - PAGE_OFF_W;
   localparam int unsigned ENT_IDX_W   = 10;
   localparam int unsigned DIR_LSB     = PAGE_OFF_W + ENT_IDX_W;
   localparam int unsigned DIR_HI_W    = ADDR_W - DIR_LSB;
   localparam int unsigned REG_SLOT_W  = 6;
   localparam int unsigned PRESENT_BIT = 8;
   localparam int unsigned SIZE_W      = 8;

   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_FETCH = 2'd1,
      WK_WAIT  = 2'd2
   } walk_state_e;

   // slots in use for a size code (entries / 1024)
   function automatic logic [REG_SLOT_W:0] slots_for_code(input logic [SIZE_W-1:0] code);
      logic [REG_SLOT_W:0] n;
      case (code)
         8'd0:    n = 7'd64;
         8'd32:   n = 7'd32;
         8'd48:   n = 7'd16;
         8'd56:   n = 7'd8;
         default: n = 7'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/apx_index.sv
module apx_index
   import apx_pkg::*;
#(
   parameter int unsigned SLOTS = 64
) (
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [ADDR_W-1:0]       ap_base,
   input  logic [SIZE_W-1:0]       ap_size_code,
   output logic [$clog2(SLOTS)-1:0] slot,
   output logic                    in_range
);

   localparam int unsigned SLOT_W = $clog2(SLOTS);

   logic [DIR_HI_W-1:0]   addr_hi, base_hi, diff;
   logic [REG_SLOT_W:0]   used_code;
   logic [DIR_HI_W-1:0]   used;

   assign addr_hi   = req_addr[ADDR_W-1:DIR_LSB];
   assign base_hi   = ap_base[ADDR_W-1:DIR_LSB];
   assign diff      = addr_hi - base_hi;
   assign used_code = slots_for_code(ap_size_code);

   // clamp slots in use to what the directory holds
   always_comb begin
      if (32'(used_code) > SLOTS) used = DIR_HI_W'(SLOTS);
      else                        used = DIR_HI_W'(used_code);
   end

   assign in_range = (addr_hi >= base_hi) && (diff < used);
   assign slot     = diff[SLOT_W-1:0];

   logic unused_idx;
   assign unused_idx = ^{req_addr[DIR_LSB-1:0], ap_base[DIR_LSB-1:0]};

endmodule

// File: rtl/apx_directory.sv
module apx_directory
   import apx_pkg::*;
#(
   parameter int unsigned SLOTS = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_data,
   input  logic [$clog2(SLOTS)-1:0] rd_slot,
   output logic                     rd_present,
   output logic [FRAME_W-1:0]       rd_frame
);

   localparam int unsigned SLOT_W = $clog2(SLOTS);

   generate
      if (SLOTS < 2 || SLOTS > 64 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("apx_directory: SLOTS must be a power of two from 2 to 64");
      end
   endgenerate

   logic [SLOTS-1:0]   present_q;
   logic [FRAME_W-1:0] frame_q [SLOTS];
   logic [REG_SLOT_W-1:0] wr_idx;
   logic                  wr_in_range;

   assign wr_idx = wr_data[REG_SLOT_W-1:0];

   generate
      if (SLOTS == (1 << REG_SLOT_W)) begin : g_full
         assign wr_in_range = 1'b1;
      end else begin : g_part
         assign wr_in_range = (wr_idx[REG_SLOT_W-1:SLOT_W] == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present_q <= '0;
         for (int s = 0; s < SLOTS; s++) frame_q[s] <= '0;
      end else if (wr_en && wr_in_range) begin
         present_q[wr_idx[SLOT_W-1:0]] <= wr_data[PRESENT_BIT];
         frame_q[wr_idx[SLOT_W-1:0]]   <= wr_data[ADDR_W-1:PAGE_OFF_W];
      end
   end

   assign rd_present = present_q[rd_slot];
   assign rd_frame   = frame_q[rd_slot];

   logic unused_dir;
   assign unused_dir = ^{wr_data[PAGE_OFF_W-1:PRESENT_BIT+1], wr_data[PRESENT_BIT-1:REG_SLOT_W]};

   // R2: a present write loads its slot
   a_r2_slot_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_in_range && wr_data[PRESENT_BIT]
      |=> present_q[$past(wr_idx[SLOT_W-1:0])]
          && frame_q[$past(wr_idx[SLOT_W-1:0])] == $past(wr_data[ADDR_W-1:PAGE_OFF_W]));

   // R3: a write with present clear empties its slot
   a_r3_slot_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_in_range && !wr_data[PRESENT_BIT]
      |=> !present_q[$past(wr_idx[SLOT_W-1:0])]);

endmodule

// File: rtl/apx_tcache.sv
module apx_tcache
   import apx_pkg::*;
#(
   parameter int unsigned WAYS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [FRAME_W-1:0] lk_tag,
   output logic               hit,
   output logic [FRAME_W-1:0] hit_frame,
   input  logic               fill_en,
   input  logic [FRAME_W-1:0] fill_tag,
   input  logic [FRAME_W-1:0] fill_frame
);

   localparam int unsigned PTR_W = $clog2(WAYS);

   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("apx_tcache: WAYS must be a power of two of at least 2");
      end
   endgenerate

   logic [WAYS-1:0]    valid_q;
   logic [FRAME_W-1:0] tag_q   [WAYS];
   logic [FRAME_W-1:0] frame_q [WAYS];
   logic [PTR_W-1:0]   ptr_q;
   logic [WAYS-1:0]    hit_vec;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign hit_vec[w] = valid_q[w] && (tag_q[w] == lk_tag);
      end
   endgenerate

   always_comb begin
      hit_frame = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_frame = hit_frame | frame_q[w];
      end
   end
   assign hit = |hit_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         ptr_q   <= '0;
         for (int w = 0; w < WAYS; w++) begin
            tag_q[w]   <= '0;
            frame_q[w] <= '0;
         end
      end else if (flush) begin
         valid_q <= '0;
         ptr_q   <= '0;
      end else if (fill_en) begin
         valid_q[ptr_q] <= 1'b1;
         tag_q[ptr_q]   <= fill_tag;
         frame_q[ptr_q] <= fill_frame;
         ptr_q          <= ptr_q + 1'b1;
      end
   end

   // R7: a page sits in at most one way
   a_r7_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R9: invalidation empties every way
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> valid_q == '0);

endmodule

// File: rtl/apx_walker.sv
module apx_walker
   import apx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic               hit,
   input  logic [FRAME_W-1:0] hit_frame,
   input  logic               in_range,
   input  logic               dir_present,
   input  logic [FRAME_W-1:0] dir_frame,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ADDR_W-1:0]  mem_rsp_data,
   output logic               rsp_valid,
   output logic [ADDR_W-1:0]  rsp_addr,
   output logic               rsp_fault,
   output logic               fill_en,
   output logic [FRAME_W-1:0] fill_tag,
   output logic [FRAME_W-1:0] fill_frame
);

   walk_state_e       st_q;
   logic [ADDR_W-1:0] va_q, fa_q, ra_q;
   logic              rv_q, rf_q;
   logic              got;

   assign req_ready     = (st_q == WK_IDLE);
   assign mem_req_valid = (st_q == WK_FETCH);
   assign mem_req_addr  = fa_q;
   assign got           = (st_q == WK_WAIT) && mem_rsp_valid;
   assign fill_en       = got && mem_rsp_data[0];
   assign fill_tag      = va_q[ADDR_W-1:PAGE_OFF_W];
   assign fill_frame    = mem_rsp_data[ADDR_W-1:PAGE_OFF_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= WK_IDLE;
         va_q <= '0;
         fa_q <= '0;
         ra_q <= '0;
         rv_q <= 1'b0;
         rf_q <= 1'b0;
      end else begin
         rv_q <= 1'b0;
         case (st_q)
            WK_IDLE: begin
               if (req_valid) begin
                  if (hit) begin
                     rv_q <= 1'b1;
                     rf_q <= 1'b0;
                     ra_q <= {hit_frame, req_addr[PAGE_OFF_W-1:0]};
                  end else if (!in_range || !dir_present) begin
                     rv_q <= 1'b1;
                     rf_q <= 1'b1;
                     ra_q <= '0;
                  end else begin
                     va_q <= req_addr;
                     fa_q <= {dir_frame, req_addr[DIR_LSB-1:PAGE_OFF_W], 2'b00};
                     st_q <= WK_FETCH;
                  end
               end
            end
            WK_FETCH: begin
               if (mem_req_ready) st_q <= WK_WAIT;
            end
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  rv_q <= 1'b1;
                  rf_q <= !mem_rsp_data[0];
                  ra_q <= mem_rsp_data[0]
                          ? {mem_rsp_data[ADDR_W-1:PAGE_OFF_W], va_q[PAGE_OFF_W-1:0]}
                          : '0;
                  st_q <= WK_IDLE;
               end
            end
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign rsp_valid = rv_q;
   assign rsp_addr  = ra_q;
   assign rsp_fault = rf_q;

   logic unused_wk;
   assign unused_wk = ^{req_addr[ADDR_W-1:DIR_LSB], va_q[DIR_LSB-1:PAGE_OFF_W],
                        mem_rsp_data[PAGE_OFF_W-1:1]};

   // R8: an unaccepted read holds its address
   a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

   // R7: a cache hit answers on the next cycle without fault
   a_r7_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && hit |=> rsp_valid && !rsp_fault);

   // R6: an entry with bit 0 clear yields a fault
   a_r6_invalid_entry: assert property (@(posedge clk) disable iff (!rst_n)
      got && !mem_rsp_data[0] |=> rsp_valid && rsp_fault);

   // R11: faults carry a zero address
   a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_addr == '0);

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
   import apx_pkg::*;
#(
   parameter int unsigned DIR_SLOTS  = 64,
   parameter int unsigned CACHE_WAYS = 4,
   parameter int unsigned FLUSH_BIT  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   ap_base,
   input  logic [SIZE_W-1:0]   ap_size_code,
   input  logic                dir_wr_en,
   input  logic [ADDR_W-1:0]   dir_wr_data,
   input  logic                ctl_wr_en,
   input  logic [ADDR_W-1:0]   ctl_wr_data,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   output logic                mem_req_valid,
   input  logic                mem_req_ready,
   output logic [ADDR_W-1:0]   mem_req_addr,
   input  logic                mem_rsp_valid,
   input  logic [ADDR_W-1:0]   mem_rsp_data,
   output logic                rsp_valid,
   output logic [ADDR_W-1:0]   rsp_addr,
   output logic                rsp_fault
);

   localparam int unsigned SLOT_W = $clog2(DIR_SLOTS);

   generate
      if (FLUSH_BIT >= ADDR_W) begin : g_bad_flush
         $error("aperture_xlate: FLUSH_BIT outside the control word");
      end
   endgenerate

   logic [SLOT_W-1:0]  slot;
   logic               in_range, dir_present, hit, fill_en;
   logic [FRAME_W-1:0] dir_frame, hit_frame, fill_tag, fill_frame;
   logic               ctl_bit_q, flush;

   // flush on a set bit that follows a write with the bit clear
   assign flush = ctl_wr_en && ctl_wr_data[FLUSH_BIT] && !ctl_bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctl_bit_q <= 1'b1;
      else if (ctl_wr_en) ctl_bit_q <= ctl_wr_data[FLUSH_BIT];
   end

   logic unused_ctl;
   assign unused_ctl = ^ctl_wr_data;

   apx_index #(.SLOTS(DIR_SLOTS)) index_i (
      .req_addr     (req_addr),
      .ap_base      (ap_base),
      .ap_size_code (ap_size_code),
      .slot         (slot),
      .in_range     (in_range)
   );

   apx_directory #(.SLOTS(DIR_SLOTS)) dir_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (dir_wr_en),
      .wr_data    (dir_wr_data),
      .rd_slot    (slot),
      .rd_present (dir_present),
      .rd_frame   (dir_frame)
   );

   apx_tcache #(.WAYS(CACHE_WAYS)) cache_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .lk_tag     (req_addr[ADDR_W-1:PAGE_OFF_W]),
      .hit        (hit),
      .hit_frame  (hit_frame),
      .fill_en    (fill_en),
      .fill_tag   (fill_tag),
      .fill_frame (fill_frame)
   );

   apx_walker walk_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .hit           (hit),
      .hit_frame     (hit_frame),
      .in_range      (in_range),
      .dir_present   (dir_present),
      .dir_frame     (dir_frame),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .rsp_valid     (rsp_valid),
      .rsp_addr      (rsp_addr),
      .rsp_fault     (rsp_fault),
      .fill_en       (fill_en),
      .fill_tag      (fill_tag),
      .fill_frame    (fill_frame)
   );

   // R10: no new request is taken while a read is pending
   a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

endmodule

// File: tb/aperture_xlate_tb_top.sv
`timescale 1ns/1ps
module aperture_xlate_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ap_base = 32'h4000_0000;
   logic [7:0]  ap_size_code = 8'd56;
   logic        dir_wr_en = 1'b0;
   logic [31:0] dir_wr_data = '0;
   logic        ctl_wr_en = 1'b0;
   logic [31:0] ctl_wr_data = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic [31:0] rsp_addr;
   logic        rsp_fault;

   always #2 clk = ~clk;

   aperture_xlate dut_i (
      .clk(clk), .rst_n(rst_n), .ap_base(ap_base), .ap_size_code(ap_size_code),
      .dir_wr_en(dir_wr_en), .dir_wr_data(dir_wr_data),
      .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
   );

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [31:0] mem_tbl [logic [31:0]];
   int          rd_count = 0;
   logic [31:0] last_rd  = '0;
   logic [31:0] pend_addr = '0;
   int          pend_cnt = 0;
   logic [3:0]  stall_cnt = '0;

   function automatic logic [31:0] lookup(input logic [31:0] a);
      if (mem_tbl.exists(a)) return mem_tbl[a];
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rsp_valid <= 1'b0;
         pend_cnt      <= 0;
      end else begin
         mem_rsp_valid <= 1'b0;
         if (pend_cnt == 1) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= lookup(pend_addr);
         end
         if (pend_cnt != 0) pend_cnt <= pend_cnt - 1;
         if (mem_req_valid && mem_req_ready) begin
            rd_count  <= rd_count + 1;
            last_rd   <= mem_req_addr;
            pend_addr <= mem_req_addr;
            pend_cnt  <= 2;
         end
      end
      stall_cnt     <= stall_cnt + 1'b1;
      mem_req_ready <= (stall_cnt[1:0] != 2'd0);
   end

   // ---------------- scoreboard ----------------
   typedef struct packed { logic fault; logic [31:0] pa; } exp_t;
   exp_t  exp_q [$];
   string tag_q [$];

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6", "unexpected response", rsp_addr, 32'h0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(rsp_fault == e.fault, t, "fault flag", {31'h0, rsp_fault}, {31'h0, e.fault});
            chk(rsp_addr == e.pa, t, "response address", rsp_addr, e.pa);
         end
      end
   end

   // ---------------- driver tasks ----------------
   task automatic dir_write(input logic [31:0] d);
      @(negedge clk);
      dir_wr_en = 1'b1; dir_wr_data = d;
      @(negedge clk);
      dir_wr_en = 1'b0;
   endtask

   task automatic ctl_write(input logic [31:0] d);
      @(negedge clk);
      ctl_wr_en = 1'b1; ctl_wr_data = d;
      @(negedge clk);
      ctl_wr_en = 1'b0;
   endtask

   // exp_reads: 0 = answered without memory (one-cycle latency), 1 = one read
   task automatic translate(input logic [31:0] va, input bit exp_fault,
                            input logic [31:0] exp_pa, input int exp_reads,
                            input logic [31:0] exp_fetch, input string tag);
      int   r0;
      int   lat;
      logic busy_rdy;
      r0 = rd_count;
      exp_q.push_back('{fault: exp_fault, pa: exp_pa});
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = va;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      busy_rdy = req_ready;
      lat = 1;
      while (!rsp_valid) begin
         @(negedge clk);
         lat++;
      end
      if (exp_reads == 0)
         chk(lat == 1, tag, "latency without read", lat, 1);
      else
         chk(busy_rdy == 1'b0, "R10", "req_ready during miss", {31'h0, busy_rdy}, 32'h0);
      @(negedge clk);
      chk(rd_count - r0 == exp_reads, tag, "memory reads", rd_count - r0, exp_reads);
      if (exp_reads == 1)
         chk(last_rd == exp_fetch, "R4", "fetch address", last_rd, exp_fetch);
   endtask

   function automatic logic [31:0] dword(input logic [19:0] frame, input logic [2:0] attr,
                                         input bit present, input logic [1:0] rsv,
                                         input logic [5:0] slot);
      return {frame, attr, present, rsv, slot};
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      mem_tbl[32'h0012_3014] = 32'hABCD_E001;
      mem_tbl[32'h0078_9004] = 32'h1111_1001;
      mem_tbl[32'h0032_1000] = 32'h2222_2001;
      mem_tbl[32'h00AA_A014] = 32'h5555_5001;
      mem_tbl[32'h00AA_A000] = 32'h6000_0001;
      mem_tbl[32'h00AA_A004] = 32'h6100_0001;
      mem_tbl[32'h00AA_A008] = 32'h6200_0001;
      mem_tbl[32'h00AA_A00C] = 32'h6300_0001;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rsp_valid == 1'b0, "R1", "rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
      chk(req_ready == 1'b1, "R1", "req_ready", {31'h0, req_ready}, 32'h1);
      translate(32'h4000_0000, 1'b1, 32'h0, 0, 32'h0, "R1");

      // R2: attribute and reserved bits set, must not matter
      dir_write(dword(20'h00123, 3'b101, 1'b1, 2'b11, 6'd0));
      translate(32'h4000_5ABC, 1'b0, 32'hABCD_EABC, 1, 32'h0012_3014, "R2");
      // R7: same page hits
      translate(32'h4000_5123, 1'b0, 32'hABCD_E123, 0, 32'h0, "R7");

      // R3: slot written present, then cleared
      dir_write(dword(20'h00456, 3'b000, 1'b1, 2'b00, 6'd3));
      dir_write(dword(20'h00456, 3'b000, 1'b0, 2'b00, 6'd3));
      translate(32'h40C0_0000, 1'b1, 32'h0, 0, 32'h0, "R3");

      // R5: size 56 gives 8 slots
      dir_write(dword(20'h00789, 3'b000, 1'b1, 2'b00, 6'd8));
      translate(32'h4200_1000, 1'b1, 32'h0, 0, 32'h0, "R5");
      translate(32'h3FFF_F000, 1'b1, 32'h0, 0, 32'h0, "R5");
      ap_size_code = 8'd48;
      translate(32'h4200_1000, 1'b0, 32'h1111_1000, 1, 32'h0078_9004, "R5");
      dir_write(dword(20'h00321, 3'b000, 1'b1, 2'b00, 6'd40));
      ap_size_code = 8'd32;
      translate(32'h4A00_0000, 1'b1, 32'h0, 0, 32'h0, "R5");
      ap_size_code = 8'd0;
      translate(32'h4A00_0000, 1'b0, 32'h2222_2000, 1, 32'h0032_1000, "R5");
      ap_size_code = 8'd7;
      translate(32'h4000_7000, 1'b1, 32'h0, 0, 32'h0, "R5");
      ap_size_code = 8'd56;

      // R6 / R10: invalid entry faults and is not cached
      translate(32'h4000_6000, 1'b1, 32'h0, 1, 32'h0012_3018, "R6");
      translate(32'h4000_6000, 1'b1, 32'h0, 1, 32'h0012_3018, "R10");

      // R9: directory rewrite keeps cached page
      dir_write(dword(20'h00AAA, 3'b000, 1'b1, 2'b00, 6'd0));
      translate(32'h4000_5000, 1'b0, 32'hABCD_E000, 0, 32'h0, "R9");
      ctl_write(32'h0000_2280);
      translate(32'h4000_5004, 1'b0, 32'hABCD_E004, 0, 32'h0, "R9");
      ctl_write(32'h0000_2200);
      translate(32'h4000_5008, 1'b0, 32'hABCD_E008, 0, 32'h0, "R9");
      ctl_write(32'h0000_2280);
      translate(32'h4000_5000, 1'b0, 32'h5555_5000, 1, 32'h00AA_A014, "R9");

      // R7: round-robin replacement evicts the oldest fill
      translate(32'h4000_0010, 1'b0, 32'h6000_0010, 1, 32'h00AA_A000, "R7");
      translate(32'h4000_1020, 1'b0, 32'h6100_0020, 1, 32'h00AA_A004, "R7");
      translate(32'h4000_2030, 1'b0, 32'h6200_0030, 1, 32'h00AA_A008, "R7");
      translate(32'h4000_3040, 1'b0, 32'h6300_0040, 1, 32'h00AA_A00C, "R7");
      translate(32'h4000_0FFF, 1'b0, 32'h6000_0FFF, 0, 32'h0, "R7");
      translate(32'h4000_5ABC, 1'b0, 32'h5555_5ABC, 1, 32'h00AA_A014, "R8");

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R8", "responses outstanding", exp_q.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule